// File: doc/BRIEF.md
# Bit-Exact 4x4 Forward Integer DCT

This block turns one 4x4 tile of signed 16-bit residual samples into 16 signed 16-bit transform coefficients. The result must match a fixed integer recipe bit for bit, so it is not an approximation of a real DCT. The tile arrives as four row beats over a valid/ready input, with one row of four samples per beat. The coefficients leave as sixteen single-value beats over a valid/ready output.

Inside, the samples are scaled up by 16, and the top-left sample gets a small bias. Two 1-D four-point butterfly passes follow. Each pass multiplies by fixed cosine constants and applies a rounded 14-bit down-shift. The first pass runs over the columns and the second over the rows of the first pass's result. A final biased quarter-scale is applied as each coefficient is stored. One combinational butterfly is shared by all eight pass steps, and only one tile is in flight at a time.

Top module: `dct4_fwd`

## Requirements
- R1: After reset, `inReady` is 1 and `outValid` is 0.
- R2: A row is taken only in a cycle where `inValid` and `inReady` are both 1. The first accepted row of a tile is row 0 and the fourth is row 3. Within `inRow`, column c occupies bits [16c+15:16c]. Cycles with `inValid` low leave the tile unchanged, whatever `inRow` carries.
- R3: Every sample is shifted left by 4 before the first pass, keeping the low 16 bits in two's complement.
- R4: 1 is added to the scaled top-left sample (row 0, column 0) only when that raw sample is nonzero. No other sample gets this bias.
- R5: Each butterfly step computes four 16-bit wrapping terms from inputs a0..a3: s0=a0+a3, s1=a1+a2, s2=a1-a2 and s3=a0-a3. It produces four 32-bit products. Product 0 is (s0+s1)*11585 and product 2 is (s0-s1)*11585, with both sums widened before the multiply. Product 1 is s3*15137+s2*6270. Product 3 is s3*6270-s2*15137.
- R6: Each product p is reduced to (p+8192)>>>14, computed without overflow, and then truncated to 16 bits.
- R7: The first pass transforms each column of the scaled tile, and output k is written to row k. The second pass transforms each row n of that result, and output m becomes final coefficient (m, n).
- R8: Each final coefficient is (v+1)>>>2 in 16-bit two's complement, where v is the second-pass value.
- R9: Coefficients leave in row-major order, (m, n) at beat 4m+n, as 16 beats. While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outCoef` stays constant.
- R10: `inReady` is 0 from the acceptance of the fourth row until the 16th coefficient has been accepted. `inReady` and `outValid` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Row beat offered |
| inReady | output | 1 | Block can take a row |
| inRow | input | 64 | Four signed samples, column c at bits [16c+15:16c] |
| outValid | output | 1 | Coefficient beat offered |
| outReady | input | 1 | Consumer takes the coefficient |
| outCoef | output | 16 | Signed coefficient, row-major order |

## Verification
Two handshakes can fall in the same clock edge: acceptance of the final coefficient of one tile, and a first row of the next tile that is already offered. The bench raises `inValid` with the next tile's row 0 during the very beat that takes the last coefficient. It then checks that this row is taken only once `inReady` has risen, by comparing that next tile's full result against an arithmetic integer model. Random output stalls and input gaps with junk data also run throughout a long sweep of tiles. The sweep covers zero, saturated, single-impulse, ramp and random tiles.

// File: rtl/dct4_fwd_pkg.sv
package dct4_fwd_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = $clog2(LANES);
  localparam int BEAT_W = 2 * LANE_W;

  localparam int COS_HI  = 15137;
  localparam int COS_MID = 11585;
  localparam int COS_LO  = 6270;

  typedef struct packed {
    logic              loadEn;
    logic              colPass;
    logic              rowPass;
    logic [LANE_W-1:0] lane;
    logic [BEAT_W-1:0] beat;
  } dct_strobe_t;
endpackage

// File: rtl/dct4_fwd_butterfly.sv
module dct4_fwd_butterfly
  import dct4_fwd_pkg::*;
#(
  parameter int W  = 16,
  parameter int PW = 32,
  parameter int FB = 14
) (
  input  logic [LANES*W-1:0] aVec,
  output logic [LANES*W-1:0] yVec
);
  localparam logic signed [PW-1:0] K_HI  = PW'(COS_HI);
  localparam logic signed [PW-1:0] K_MID = PW'(COS_MID);
  localparam logic signed [PW-1:0] K_LO  = PW'(COS_LO);
  localparam logic [PW:0] HALF = {{(PW-FB+1){1'b0}}, 1'b1, {(FB-1){1'b0}}};

  logic signed [W-1:0]  a0, a1, a2, a3, s0, s1, s2, s3;
  logic signed [PW-1:0] e0, e1, e2, e3, p0, p1, p2, p3;

  function automatic logic [W-1:0] rndNarrow(input logic signed [PW-1:0] p);
    logic signed [PW:0] t;
    t = $signed({p[PW-1], p}) + $signed(HALF);
    t = t >>> FB;
    return t[W-1:0];
  endfunction

  always_comb begin
    a0 = aVec[0*W +: W];
    a1 = aVec[1*W +: W];
    a2 = aVec[2*W +: W];
    a3 = aVec[3*W +: W];
    s0 = a0 + a3;
    s1 = a1 + a2;
    s2 = a1 - a2;
    s3 = a0 - a3;
    e0 = PW'(s0);
    e1 = PW'(s1);
    e2 = PW'(s2);
    e3 = PW'(s3);
    p0 = (e0 + e1) * K_MID;
    p2 = (e0 - e1) * K_MID;
    p1 = e3 * K_HI + e2 * K_LO;
    p3 = e3 * K_LO - e2 * K_HI;
    yVec = {rndNarrow(p3), rndNarrow(p2), rndNarrow(p1), rndNarrow(p0)};
  end
endmodule

// File: rtl/dct4_fwd_datapath.sv
module dct4_fwd_datapath
  import dct4_fwd_pkg::*;
#(
  parameter int W    = 16,
  parameter int PW   = 32,
  parameter int FB   = 14,
  parameter int PRE  = 4,
  parameter int POST = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dct_strobe_t        stb,
  input  logic [LANES*W-1:0] inRow,
  output logic [W-1:0]       coef
);
  logic signed [W-1:0] bufX [LANES][LANES];
  logic signed [W-1:0] bufY [LANES][LANES];
  logic [LANES*W-1:0] opVec, resVec, scaledRow;

  function automatic logic signed [W-1:0] postScale(input logic signed [W-1:0] v);
    logic signed [W-1:0] t;
    t = v + W'(1);
    return t >>> POST;
  endfunction

  // column pass reads a column, row pass reads a row
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      opVec[k*W +: W] = stb.colPass ? bufX[k][stb.lane] : bufX[stb.lane][k];
    end
  end

  dct4_fwd_butterfly #(.W(W), .PW(PW), .FB(FB)) u_bfly (
    .aVec(opVec),
    .yVec(resVec)
  );

  for (genvar c = 0; c < LANES; c++) begin : g_pre
    logic signed [W-1:0] raw, shifted;
    assign raw     = inRow[c*W +: W];
    assign shifted = raw <<< PRE;
    if (c == 0) begin : g_dc
      assign scaledRow[c*W +: W] = (stb.lane == '0 && raw != '0) ? shifted + W'(1) : shifted;
    end else begin : g_ac
      assign scaledRow[c*W +: W] = shifted;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < LANES; r++) begin
        for (int c = 0; c < LANES; c++) begin
          bufX[r][c] <= '0;
          bufY[r][c] <= '0;
        end
      end
    end else if (stb.loadEn) begin
      for (int c = 0; c < LANES; c++) bufX[stb.lane][c] <= scaledRow[c*W +: W];
    end else if (stb.colPass) begin
      for (int k = 0; k < LANES; k++) bufX[k][stb.lane] <= resVec[k*W +: W];
    end else if (stb.rowPass) begin
      for (int m = 0; m < LANES; m++) bufY[m][stb.lane] <= postScale(resVec[m*W +: W]);
    end
  end

  assign coef = bufY[stb.beat[BEAT_W-1:LANE_W]][stb.beat[LANE_W-1:0]];

  AST_DC_BIAS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadEn && stb.lane == '0) |=> (bufX[0][0][PRE-1:0] == PRE'($past(inRow[W-1:0] != '0)))); // R4
  AST_AC_SCALE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadEn && stb.lane == '0) |=> (bufX[0][1][PRE-1:0] == '0)); // R3
endmodule

// File: rtl/dct4_fwd_ctrl.sv
module dct4_fwd_ctrl
  import dct4_fwd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  output dct_strobe_t stb
);
  typedef enum logic [1:0] {PH_LOAD, PH_COLS, PH_ROWS, PH_EMIT} phase_t;
  localparam logic [BEAT_W-1:0] LAST_LANE = BEAT_W'(LANES - 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LANES * LANES - 1);

  phase_t phase;
  logic [BEAT_W-1:0] cnt;
  logic take, give;

  always_comb begin
    inReady     = (phase == PH_LOAD);
    outValid    = (phase == PH_EMIT);
    take        = inValid && inReady;
    give        = outValid && outReady;
    stb.loadEn  = take;
    stb.colPass = (phase == PH_COLS);
    stb.rowPass = (phase == PH_ROWS);
    stb.lane    = cnt[LANE_W-1:0];
    stb.beat    = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_LOAD;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_LOAD: if (take) begin
          if (cnt == LAST_LANE) begin phase <= PH_COLS; cnt <= '0; end
          else cnt <= cnt + BEAT_W'(1);
        end
        PH_COLS: begin
          if (cnt == LAST_LANE) begin phase <= PH_ROWS; cnt <= '0; end
          else cnt <= cnt + BEAT_W'(1);
        end
        PH_ROWS: begin
          if (cnt == LAST_LANE) begin phase <= PH_EMIT; cnt <= '0; end
          else cnt <= cnt + BEAT_W'(1);
        end
        PH_EMIT: if (give) begin
          if (cnt == LAST_BEAT) begin phase <= PH_LOAD; cnt <= '0; end
          else cnt <= cnt + BEAT_W'(1);
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadEn, stb.colPass, stb.rowPass, outValid})); // R10
  AST_BUSY_NO_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady); // R10
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(stb.beat))); // R9
  AST_LAST_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outValid) |-> ($past(stb.beat) == LAST_BEAT && $past(outReady))); // R9
  AST_EMIT_AFTER_ROWS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> ($past(stb.rowPass) && $past(stb.lane) == LAST_LANE[LANE_W-1:0])); // R7
endmodule

// File: rtl/dct4_fwd.sv
module dct4_fwd
  import dct4_fwd_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int PROD_W    = 32,
  parameter int FRAC_BITS = 14,
  parameter int PRE_SHIFT = 4,
  parameter int POST_SHIFT = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [LANES*SAMPLE_W-1:0] inRow,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [SAMPLE_W-1:0]       outCoef
);
  dct_strobe_t stb;

  dct4_fwd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .stb(stb)
  );

  dct4_fwd_datapath #(
    .W(SAMPLE_W), .PW(PROD_W), .FB(FRAC_BITS), .PRE(PRE_SHIFT), .POST(POST_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inRow(inRow), .coef(outCoef)
  );

  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outCoef)); // R9
endmodule

// File: tb/dct4_fwd_tb.sv
`timescale 1ns/1ps
module dct4_fwd_tb;
  logic clk = 0, rstN, inValid, inReady, outValid, outReady;
  logic [63:0] inRow;
  logic [15:0] outCoef;
  int checks = 0, errors = 0;
  localparam int NB = 180;

  always #10 clk = ~clk;

  dct4_fwd u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inRow(inRow),
    .outValid(outValid), .outReady(outReady), .outCoef(outCoef)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, $signed(act), $signed(exp));
    end
  endtask

  function automatic logic signed [15:0] rnd14(input logic signed [31:0] p);
    logic signed [32:0] t;
    t = $signed({p[31], p}) + 33'sd8192;
    t = t >>> 14;
    return t[15:0];
  endfunction

  task automatic bfly(input logic signed [15:0] a0, a1, a2, a3,
                      output logic signed [15:0] o0, o1, o2, o3);
    logic signed [15:0] s0, s1, s2, s3;
    logic signed [31:0] w0, w1, w2, w3;
    s0 = a0 + a3; s1 = a1 + a2; s2 = a1 - a2; s3 = a0 - a3;
    w0 = 32'(s0); w1 = 32'(s1); w2 = 32'(s2); w3 = 32'(s3);
    o0 = rnd14((w0 + w1) * 32'sd11585);
    o2 = rnd14((w0 - w1) * 32'sd11585);
    o1 = rnd14(w3 * 32'sd15137 + w2 * 32'sd6270);
    o3 = rnd14(w3 * 32'sd6270 - w2 * 32'sd15137);
  endtask

  task automatic refDct(input logic signed [15:0] x[16], output logic signed [15:0] y[16]);
    logic signed [15:0] p[16], a[16], z[16], t;
    for (int i = 0; i < 16; i++) p[i] = x[i] <<< 4;   // R3
    if (x[0] != 0) p[0] = p[0] + 16'sd1;              // R4
    for (int c = 0; c < 4; c++)                       // R7 column pass
      bfly(p[c], p[4+c], p[8+c], p[12+c], a[c], a[4+c], a[8+c], a[12+c]);
    for (int n = 0; n < 4; n++)                       // R7 row pass
      bfly(a[4*n], a[4*n+1], a[4*n+2], a[4*n+3], z[n], z[4+n], z[8+n], z[12+n]);
    for (int i = 0; i < 16; i++) begin                // R8
      t = z[i] + 16'sd1;
      y[i] = t >>> 2;
    end
  endtask

  function automatic logic [63:0] packRow(input logic signed [15:0] x[16], input int r);
    logic [63:0] v;
    for (int c = 0; c < 4; c++) v[c*16 +: 16] = x[r*4+c];
    return v;
  endfunction

  task automatic genBlock(input int b, output logic signed [15:0] x[16], output string tag);
    int unsigned v;
    for (int i = 0; i < 16; i++) begin
      v = $urandom;
      if (b == 0) x[i] = 0;
      else if (b == 1) x[i] = (i == 0) ? 16'sd1 : 16'sd0;
      else if (b == 2) x[i] = (i == 0) ? -16'sd1 : 16'sd0;
      else if (b == 3) x[i] = 16'sh7fff;
      else if (b == 4) x[i] = 16'sh8000;
      else if (b <= 20) x[i] = (i == b - 5) ? 16'sd100 : 16'sd0;
      else if (b == 21) x[i] = 16'(i * 37 - 300);
      else if (b % 3 == 0) x[i] = 16'(v);
      else if (b % 3 == 1) x[i] = 16'(v % 511) - 16'd255;
      else x[i] = 16'(v % 31) - 16'd15;
    end
    if (b <= 2) tag = "R4";
    else if (b <= 4) tag = "R3";
    else if (b <= 20) tag = "R7";
    else if (b == 21) tag = "R5";
    else if (b % 2 == 1) tag = "R2";
    else if (b % 4 == 0) tag = "R6";
    else tag = "R8";
  endtask

  task automatic sendBlock(input logic signed [15:0] x[16], input bit gaps);
    for (int r = 0; r < 4; r++) begin
      if (gaps) begin
        @(negedge clk);
        inValid = 0;
        inRow = {$urandom, $urandom};   // R2 junk while idle
      end
      @(negedge clk);
      inValid = 1;
      inRow = packRow(x, r);
      while (!inReady) @(negedge clk);
    end
  endtask

  task automatic recvBlock(input logic signed [15:0] e[16], input string tag, input bit stalls,
                           input logic [63:0] nextRow, input bit haveNext);
    int idx = 0;
    bit held = 0;
    logic [15:0] hv = '0;
    while (idx < 16) begin
      @(negedge clk);
      outReady = !(stalls && ($urandom % 3 == 0));
      if (outValid) begin
        if (held) begin
          chk("R9", outCoef, hv, "coefficient under stall");
          held = 0;
        end
        if (outReady) begin
          chk(tag, outCoef, e[idx], $sformatf("coef %0d", idx));
          chk("R10", {15'd0, inReady}, 16'd0, "inReady while emitting");
          if (idx == 15 && haveNext) begin
            inValid = 1;           // next tile's row 0 offered in the last-beat cycle
            inRow = nextRow;
          end
          idx++;
        end else begin
          held = 1;
          hv = outCoef;
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hang expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic signed [15:0] blk[16], nxt[16], expY[16];
    string tag, ntag;
    rstN = 0; inValid = 0; outReady = 0; inRow = '0;
    repeat (3) @(negedge clk);
    chk("R1", {15'd0, inReady}, 16'd1, "inReady in reset");
    chk("R1", {15'd0, outValid}, 16'd0, "outValid in reset");
    rstN = 1;
    @(negedge clk);
    chk("R1", {15'd0, inReady}, 16'd1, "inReady after reset");
    chk("R1", {15'd0, outValid}, 16'd0, "outValid after reset");
    genBlock(0, blk, tag);
    for (int b = 0; b < NB; b++) begin
      if (b + 1 < NB) genBlock(b + 1, nxt, ntag);
      refDct(blk, expY);
      sendBlock(blk, (b >= 22) && (b % 2 == 1));
      @(negedge clk);
      inValid = 0;
      recvBlock(expY, tag, b >= 22, packRow(nxt, 0), b + 1 < NB);
      blk = nxt;
      tag = ntag;
    end
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule